// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block owns the chip-select lines of an SPI controller and frames each transfer that a separate shift engine performs. A small register set chooses which line is used, the idle level of every line, the select policy, and four 8-bit delays. When the shift engine has a frame waiting (`frame_req`), the sequencer asserts the chosen line, waits out a lead-in delay, then holds `frame_start` high until the engine reports `frame_done`. Then, depending on the policy, it either releases the line after a tail delay and keeps it released for a minimum idle time, or keeps the line asserted and spaces the next frame by an inter-frame gap.

All delays are counted in serial-clock periods. The shift engine's clock divider supplies these as single-cycle `sck_tick` pulses. A delay of zero still takes one system-clock cycle. There are three policies: per-frame automatic select, select held across frames, and select disabled. With the select disabled, frames still run but no line moves. The number of lines is a parameter, up to 32. Software can find it by writing all ones to the idle-level register and reading it back.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset every line sits at its idle level, `frame_start` is low, and the registers read: address 0 (line select) 0, address 1 (idle levels) ones in the low NCS bits, address 2 (policy) 0, address 3 `0x00010001`, address 4 `0x00000001`.
- R2: Address 1 holds one idle-level bit per line in bit i for line i. Bits at NCS and above read back as zero. An idle line follows its bit within one cycle of the write.
- R3: With policy code 3 (disabled), frames still receive `frame_start` and complete, and every line stays at its idle level.
- R4: Only the line named by address 0 (bits IDW-1:0) ever leaves its idle level. While active it drives the inverse of its idle bit, and at most one line is active at a time.
- R5: With policy code 0 (automatic) and `sck_tick` high every cycle, the line is active for max(L,1) cycles before `frame_start` rises, where L is address 3 bits 7:0.
- R6: In automatic policy, the line stays active for max(T,1) cycles after the edge that samples `frame_done`, where T is address 3 bits 23:16.
- R7: In automatic policy with a further frame pending, the line stays idle for max(I,1) cycles before it is asserted again, where I is address 4 bits 7:0.
- R8: With policy code 2 (held), the line stays active between frames, and `frame_start` stays low for max(G,1) cycles between frames, where G is address 4 bits 23:16.
- R9: A held line whose policy changes to automatic with no frame pending is released max(T,1)+1 cycles after the edge that stores the new policy.
- R10: Delay counters advance only on `sck_tick`. A non-zero delay never ends while `sck_tick` is low, and a zero delay ends without any tick.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 select, 1 idle levels, 2 policy, 3 lead/tail, 4 idle/gap) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| sck_tick | input | 1 | One pulse per serial-clock period |
| frame_req | input | 1 | Shift engine has a frame waiting |
| frame_start | output | 1 | Permission for the shift engine to shift the current frame |
| frame_done | input | 1 | Shift engine has produced its last edge of the frame |
| cs_line | output | NCS | Chip-select lines |

## Verification
Register writes take effect on the next edge. An idle line therefore shows its new level at the half-cycle sample after the write, and read data is combinational. With ticks every cycle, each phase of the select sequence lasts a fixed number of cycles: lead max(L,1), tail max(T,1), idle max(I,1), held gap max(G,1). A release after a policy change takes one cycle more, because the new policy must first be stored. The bench samples half a cycle after each edge, splits the `cs_line`/`frame_start` trace into segments, and compares each segment length against these formulas over a sweep of delay values, lines and idle patterns.

// File: rtl/spi_csq_pkg.sv
package spi_csq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TRAIL,
    ST_GAP,
    ST_HELD,
    ST_REST
  } csq_state_e;

  localparam logic [2:0] A_SEL  = 3'd0;
  localparam logic [2:0] A_DFLT = 3'd1;
  localparam logic [2:0] A_MODE = 3'd2;
  localparam logic [2:0] A_DLY0 = 3'd3;
  localparam logic [2:0] A_DLY1 = 3'd4;

  localparam logic [1:0] MODE_HOLD = 2'd2;
  localparam logic [1:0] MODE_OFF  = 2'd3;

  typedef struct packed {
    logic [7:0] lead;
    logic [7:0] trail;
    logic [7:0] rest;
    logic [7:0] gap;
  } csq_delays_t;

endpackage

// File: rtl/csq_regs.sv
module csq_regs
  import spi_csq_pkg::*;
#(
  parameter int NCS = 32,
  parameter int IDW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [IDW-1:0]    sel_id,
  output logic [NCS-1:0]    dflt,
  output logic [1:0]        mode,
  output csq_delays_t       dly
);

  logic [IDW-1:0] sel_q, sel_d;
  logic [NCS-1:0] dflt_q, dflt_d;
  logic [1:0]     mode_q, mode_d;
  csq_delays_t    dly_q, dly_d;
  logic [31:0]    sel_ext, dflt_ext;
  logic           unused_wbits;

  assign unused_wbits = ^{wdata[31:24], wdata[15:8]};

  always_comb begin
    sel_d  = sel_q;
    dflt_d = dflt_q;
    mode_d = mode_q;
    dly_d  = dly_q;
    if (we) begin
      case (addr)
        A_SEL:  sel_d  = wdata[IDW-1:0];
        A_DFLT: dflt_d = wdata[NCS-1:0];
        A_MODE: mode_d = wdata[1:0];
        A_DLY0: begin
          dly_d.lead  = wdata[7:0];
          dly_d.trail = wdata[23:16];
        end
        A_DLY1: begin
          dly_d.rest = wdata[7:0];
          dly_d.gap  = wdata[23:16];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dflt_q <= '1;
      mode_q <= '0;
      dly_q  <= '{lead: 8'd1, trail: 8'd1, rest: 8'd1, gap: 8'd0};
    end else if (we) begin
      sel_q  <= sel_d;
      dflt_q <= dflt_d;
      mode_q <= mode_d;
      dly_q  <= dly_d;
    end
  end

  always_comb begin
    sel_ext  = '0;
    sel_ext[IDW-1:0] = sel_q;
    dflt_ext = '0;
    dflt_ext[NCS-1:0] = dflt_q;
  end

  always_comb begin
    case (addr)
      A_SEL:   rdata = sel_ext;
      A_DFLT:  rdata = dflt_ext;
      A_MODE:  rdata = {30'd0, mode_q};
      A_DLY0:  rdata = {8'd0, dly_q.trail, 8'd0, dly_q.lead};
      A_DLY1:  rdata = {8'd0, dly_q.gap, 8'd0, dly_q.rest};
      default: rdata = '0;
    endcase
  end

  assign sel_id = sel_q;
  assign dflt   = dflt_q;
  assign mode   = mode_q;
  assign dly    = dly_q;

  p_dflt_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_DFLT) |=> (dflt_q == $past(wdata[NCS-1:0])));

endmodule

// File: rtl/csq_delay.sv
module csq_delay (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [7:0] limit,
  output logic       expire
);

  logic [7:0] cnt_q, cnt_d;
  logic       cnt_en;

  assign expire = (limit == 8'd0) ||
                  (tick && ({1'b0, cnt_q} + 9'd1 >= {1'b0, limit}));

  assign cnt_en = clr || (tick && cnt_q != 8'hFF);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (tick && cnt_q != 8'hFF)
      cnt_d = cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  p_frozen_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/csq_fsm.sv
module csq_fsm
  import spi_csq_pkg::*;
#(
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           done,
  input  logic           expire,
  input  logic [1:0]     mode,
  input  logic [IDW-1:0] sel_id,
  input  csq_delays_t    dly,
  output logic           start,
  output logic           cs_on,
  output logic [IDW-1:0] act_id,
  output logic [7:0]     limit,
  output logic           clr
);

  csq_state_e     state_q, state_d;
  logic           cs_on_q, cs_on_d;
  logic [IDW-1:0] id_q, id_d;
  logic           is_hold, is_off;

  assign is_hold = (mode == MODE_HOLD);
  assign is_off  = (mode == MODE_OFF);

  always_comb begin
    state_d = state_q;
    cs_on_d = cs_on_q;
    id_d    = id_q;
    case (state_q)
      ST_IDLE: if (req) begin
        if (is_off) begin
          state_d = ST_XFER;
        end else begin
          state_d = ST_LEAD;
          cs_on_d = 1'b1;
          id_d    = sel_id;
        end
      end
      ST_LEAD: if (expire) state_d = ST_XFER;
      ST_XFER: if (done) begin
        if (!cs_on_q)     state_d = ST_IDLE;
        else if (is_hold) state_d = ST_GAP;
        else              state_d = ST_TRAIL;
      end
      ST_GAP: if (expire) begin
        if (!is_hold)     state_d = ST_TRAIL;
        else if (req)     state_d = ST_XFER;
        else              state_d = ST_HELD;
      end
      ST_HELD: begin
        if (!is_hold)     state_d = ST_TRAIL;
        else if (req)     state_d = ST_XFER;
      end
      ST_TRAIL: if (expire) begin
        state_d = ST_REST;
        cs_on_d = 1'b0;
      end
      ST_REST: if (expire) begin
        if (req && !is_off) begin
          state_d = ST_LEAD;
          cs_on_d = 1'b1;
          id_d    = sel_id;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (state_q)
      ST_LEAD:  limit = dly.lead;
      ST_TRAIL: limit = dly.trail;
      ST_REST:  limit = dly.rest;
      ST_GAP:   limit = dly.gap;
      default:  limit = 8'd0;
    endcase
  end

  assign clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_on_q <= 1'b0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      cs_on_q <= cs_on_d;
      id_q    <= id_d;
    end
  end

  assign start  = (state_q == ST_XFER);
  assign cs_on  = cs_on_q;
  assign act_id = id_q;

  p_off_never_asserts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_on_q) |-> $past(mode != MODE_OFF));

  p_release_after_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_on_q) |-> $past(state_q == ST_TRAIL));

  p_held_between_frames_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP || state_q == ST_HELD) |-> cs_on_q);

  p_leave_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && mode != MODE_HOLD) |=> (state_q == ST_TRAIL));

endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import spi_csq_pkg::*;
#(
  parameter int NCS = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_addr,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  input  logic           sck_tick,
  input  logic           frame_req,
  output logic           frame_start,
  input  logic           frame_done,
  output logic [NCS-1:0] cs_line
);

  localparam int IDW = (NCS > 1) ? $clog2(NCS) : 1;

  logic [IDW-1:0] sel_id, act_id;
  logic [NCS-1:0] dflt;
  logic [1:0]     mode;
  csq_delays_t    dly;
  logic           expire, clr, cs_on;
  logic [7:0]     limit;

  csq_regs #(.NCS(NCS), .IDW(IDW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .sel_id (sel_id),
    .dflt   (dflt),
    .mode   (mode),
    .dly    (dly)
  );

  csq_fsm #(.IDW(IDW)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (frame_req),
    .done   (frame_done),
    .expire (expire),
    .mode   (mode),
    .sel_id (sel_id),
    .dly    (dly),
    .start  (frame_start),
    .cs_on  (cs_on),
    .act_id (act_id),
    .limit  (limit),
    .clr    (clr)
  );

  csq_delay u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .tick   (sck_tick),
    .limit  (limit),
    .expire (expire)
  );

  for (genvar gi = 0; gi < NCS; gi++) begin : g_line
    assign cs_line[gi] = dflt[gi] ^ (cs_on && (act_id == IDW'(gi)));
  end

  p_single_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_line ^ dflt) <= 1);

  p_select_before_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frame_start) && cs_on) |-> $past(cs_on));

endmodule

// File: tb/test_spi_cs_sequencer.sv
module test_spi_cs_sequencer;
  localparam int NCS = 6;
  localparam int CLK_PERIOD = 10;

  logic           clk, rst_n, cfg_we, sck_tick, frame_req, frame_start, frame_done;
  logic [2:0]     cfg_addr;
  logic [31:0]    cfg_wdata, cfg_rdata;
  logic [NCS-1:0] cs_line;

  int n_chk = 0, n_bad = 0;
  int pending = 0, frame_len = 2, eng_run = 0;
  logic [NCS-1:0] exp_dflt = '1;
  int exp_id = 0, exp_lead = 1, exp_trail = 1, exp_inact = 1, exp_gap = 1;
  bit chk_lead = 0, chk_trail = 0, chk_inact = 0, chk_gap = 0, skip_inact = 1, off_run = 0;
  logic [1:0] prv = 2'b00, pprv = 2'b01;
  int seg = 0;

  assign frame_req = (pending != 0);

  spi_cs_sequencer #(.NCS(NCS)) i_spi_cs_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sck_tick(sck_tick),
    .frame_req(frame_req), .frame_start(frame_start), .frame_done(frame_done),
    .cs_line(cs_line)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic bit line_active();
    return cs_line[exp_id] != exp_dflt[exp_id];
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((pending != 0 || line_active() || frame_start) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
  endtask

  // shift engine model: done after frame_len cycles of start
  initial begin
    frame_done = 1'b0;
    forever begin
      @(negedge clk);
      frame_done = 1'b0;
      if (frame_start) begin
        eng_run++;
        if (eng_run == frame_len) begin
          frame_done = 1'b1;
          pending--;
          eng_run = 0;
        end
      end else begin
        eng_run = 0;
      end
    end
  end

  // segment monitor, half a cycle after each rising edge
  initial begin
    logic [1:0] cur;
    bit bad_other;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        bad_other = 1'b0;
        for (int i = 0; i < NCS; i++)
          if (i != exp_id && cs_line[i] != exp_dflt[i]) bad_other = 1'b1;
        check(!bad_other, "R4 unselected line moved", cs_line, exp_dflt);
        if (off_run) check(cs_line == exp_dflt, "R3 line moved in disabled policy", cs_line, exp_dflt);
        cur = {line_active(), frame_start};
        if (cur != prv) begin
          if (prv == 2'b10 && cur == 2'b11) begin
            if (pprv == 2'b00 && chk_lead) check(seg == exp_lead, "R5 lead", seg, exp_lead);
            if (pprv == 2'b11 && chk_gap)  check(seg == exp_gap, "R8 gap", seg, exp_gap);
          end
          if (prv == 2'b10 && cur == 2'b00 && pprv == 2'b11 && chk_trail)
            check(seg == exp_trail, "R6 tail", seg, exp_trail);
          if (prv == 2'b00 && cur == 2'b10) begin
            if (skip_inact) skip_inact = 1'b0;
            else if (pprv == 2'b10 && chk_inact) check(seg == exp_inact, "R7 idle", seg, exp_inact);
          end
          pprv = prv;
          prv  = cur;
          seg  = 1;
        end else begin
          seg++;
        end
      end
    end
  end

  task automatic auto_run(input int a, input int b, input int c, input int id,
                          input logic [31:0] dv, input int frames);
    wr(3'd0, id); wr(3'd1, dv); exp_dflt = dv[NCS-1:0]; exp_id = id;
    wr(3'd2, 32'd0);
    wr(3'd3, {8'd0, b[7:0], 8'd0, a[7:0]});
    wr(3'd4, {24'd0, c[7:0]});
    exp_lead = mx1(a); exp_trail = mx1(b); exp_inact = mx1(c);
    chk_lead = 1; chk_trail = 1; chk_inact = 1; chk_gap = 0; skip_inact = 1;
    pending = frames;
    wait_idle();
    check(pending == 0, "R5 frames completed", pending, 0);
  endtask

  task automatic hold_run(input int a, input int g, input int b, input int id,
                          input logic [31:0] dv, input int frames);
    int cnt;
    wr(3'd0, id); wr(3'd1, dv); exp_dflt = dv[NCS-1:0]; exp_id = id;
    wr(3'd2, 32'd2);
    wr(3'd3, {8'd0, b[7:0], 8'd0, a[7:0]});
    wr(3'd4, {8'd0, g[7:0], 16'd1});
    exp_lead = mx1(a); exp_gap = mx1(g);
    chk_lead = 1; chk_trail = 0; chk_inact = 0; chk_gap = 1; skip_inact = 1;
    pending = frames;
    cnt = 0;
    while ((pending != 0 || frame_start) && cnt < 3000) begin @(negedge clk); cnt++; end
    repeat (20) @(negedge clk);
    check(line_active(), "R8 held after last frame", line_active(), 1);
    wr(3'd2, 32'd0);
    cnt = 0;
    while (line_active() && cnt < 600) begin cnt++; @(negedge clk); end
    check(cnt == mx1(b) + 1, "R9 release after leaving hold", cnt, mx1(b) + 1);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int run;
    int dv[4] = '{0, 1, 2, 5};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; sck_tick = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_line == 6'h3F, "R1 reset lines", cs_line, 6'h3F);
    check(frame_start == 1'b0, "R1 reset start", frame_start, 0);
    rd(3'd0, d); check(d == 32'd0, "R1 reset select", d, 0);
    rd(3'd1, d); check(d == 32'h3F, "R1 reset idle levels", d, 32'h3F);
    rd(3'd2, d); check(d == 32'd0, "R1 reset policy", d, 0);
    rd(3'd3, d); check(d == 32'h00010001, "R1 reset lead/tail", d, 32'h00010001);
    rd(3'd4, d); check(d == 32'h00000001, "R1 reset idle/gap", d, 32'h00000001);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: idle-level register
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check(d == 32'h3F, "R2 unimplemented bits read zero", d, 32'h3F);
    wr(3'd1, 32'hFFFF_FF15); exp_dflt = 6'h15;
    #2 check(cs_line == 6'h15, "R2 idle lines follow register", cs_line, 6'h15);
    rd(3'd1, d); check(d == 32'h15, "R2 readback", d, 32'h15);
    @(negedge clk);

    // R5 R6 R7 sweep in automatic policy
    run = 0;
    for (int ia = 0; ia < 4; ia++)
      for (int ib = 0; ib < 4; ib++)
        for (int ic = 0; ic < 4; ic++) begin
          auto_run(dv[ia], dv[ib], dv[ic], run % NCS, (run % 2 != 0) ? 32'h35 : 32'h3F, 3);
          run++;
        end

    // R8 R9 sweep in held policy
    for (int ia = 0; ia < 4; ia++)
      for (int ig = 0; ig < 4; ig++)
        for (int ib = 0; ib < 2; ib++) begin
          hold_run(dv[ia], dv[ig], ib * 3, run % NCS, (run % 2 != 0) ? 32'h3F : 32'h2A, 3);
          run++;
        end

    // R3: disabled policy
    chk_lead = 0; chk_trail = 0; chk_inact = 0; chk_gap = 0;
    wr(3'd2, 32'd3);
    off_run = 1;
    pending = 3;
    wait_idle();
    off_run = 0;
    check(pending == 0, "R3 frames run while disabled", pending, 0);

    // R10: no tick, non-zero lead never ends
    wr(3'd2, 32'd0);
    wr(3'd3, 32'h0001_0003);
    wr(3'd4, 32'h0000_0001);
    sck_tick = 1'b0; skip_inact = 1;
    pending = 1;
    repeat (30) @(negedge clk);
    check(line_active() && !frame_start, "R10 lead waits for tick", frame_start, 0);
    sck_tick = 1'b1;
    wait_idle();
    check(pending == 0, "R10 frame ends once ticks resume", pending, 0);

    // R10: zero delays finish without ticks
    wr(3'd3, 32'd0); wr(3'd4, 32'd0);
    exp_lead = 1; exp_trail = 1; exp_inact = 1;
    chk_lead = 1; chk_trail = 1; chk_inact = 1; skip_inact = 1;
    sck_tick = 1'b0;
    pending = 2;
    wait_idle();
    check(pending == 0, "R10 zero delays need no tick", pending, 0);
    sck_tick = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule